// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM Access Controller

This block is the control path of a pipelined synchronous static RAM. It holds a small memory array organised as words of four 8-bit lanes. Every control input is captured in a register on the rising clock edge. The captured cycle is then decoded into a read, a write with a per-lane write mask, or no operation. Read data leaves through an output register and is driven only while an asynchronous output enable is held low. When not driven, the data output is treated as high-impedance, modelled here as `dq_en` low and `dq_out` at zero.

A transfer starts through one of two start strobes:

- **Processor strobe.** It needs only the primary select and always reads on its own edge.
- **Controller strobe.** It needs all three selects. It reads or writes according to the write inputs. When the selects do not all match, it ends the current transfer.

After a start, cycles with neither strobe low continue the transfer at whatever address an external sequencer presents. Each such cycle again reads or writes according to the write inputs.

A sleep input puts the block into power-down. While asleep, and for three sampled edges after sleep is released, nothing is accepted, the array keeps its contents and the outputs stay undriven.

Top module: `sram_sync_core`

## Requirements
- R1: While reset is held, `dq_en` is 0 and `dq_out` is zero.
- R2: When an accepted cycle writes with `gwr_n` high and `bwr_n` low, lane i (bits 8i+7..8i) is written exactly when `lane_n[i]` is 0. Lane 0 is bits 7..0 and lane 3 is bits 31..24. Lanes with `lane_n[i]` at 1 keep their old contents.
- R3: An accepted cycle with `gwr_n` low writes all four lanes, whatever the values of `bwr_n` and `lane_n`.
- R4: An accepted cycle with `gwr_n` high, and with either `bwr_n` high or `lane_n` equal to 4'b1111, is a read and changes no memory content.
- R5: A processor start (`pstb_n` low with `sel_a_n` low) always performs a read, even when the write inputs request a write. A write to that transfer takes effect only on a following continue cycle whose write inputs request it.
- R6: A controller start (`cstb_n` low) is accepted only when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. Otherwise it performs no access and ends the transfer, so that later continue cycles are ignored.
- R7: A processor strobe with `sel_a_n` high is ignored when `cstb_n` is high. It neither accesses the array nor starts a transfer.
- R8: Read data for the address sampled at edge k appears on `dq_out` with `dq_en` high after edge k+1. A read on the cycle right after a write to the same address returns the new data.
- R9: `dq_en` is low whenever `oe_n` is high, and it follows `oe_n` without waiting for a clock edge.
- R10: While `sleep` is sampled high, and at the first three edges at which it is sampled low after that, no access is accepted, the transfer ends, the memory is preserved and `dq_en` stays low. The fourth such edge accepts normally.
- R11: After an accepted start, a cycle with both strobes high reads or writes, according to the write inputs, at the address presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address from the burst sequencer |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data, zero when not driven |
| dq_en | output | 1 | High while `dq_out` is driven |
| sel_a_n | input | 1 | Primary chip select, active low |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| pstb_n | input | 1 | Processor start strobe, active low |
| cstb_n | input | 1 | Controller start strobe, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |

## Verification
The embedded properties check on every cycle that:

- a processor start never produces a write mask;
- a global write sets every lane;
- a lane write follows the inverted lane enables;
- a mismatched controller start clears the transfer;
- power-down and wake-up suppress every strobe;
- the output is driven only after a decoded read.

Only the bench scenarios can show what actually lands in the array. These include partial-lane merges that build up over several writes, and writes that were suppressed by a deselect or by sleep and show up as unchanged data on a later read. They also cover the exact count of blocked wake-up edges and the asynchronous release of the output by `oe_n` between two clock edges.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   // Registered control bundle captured at each rising edge.
   typedef struct packed {
      logic sel_a_n;
      logic sel_b;
      logic sel_c_n;
      logic pstb_n;
      logic cstb_n;
      logic gwr_n;
      logic bwr_n;
      logic sleep;
   } ctl_t;

   localparam ctl_t CTL_IDLE = '{sel_a_n: 1'b1, sel_b: 1'b0, sel_c_n: 1'b1,
                                 pstb_n: 1'b1, cstb_n: 1'b1, gwr_n: 1'b1,
                                 bwr_n: 1'b1, sleep: 1'b0};

endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl_d,
   input  logic [LANES-1:0]  lane_d,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic [DATA_W-1:0] data_d,
   output ctl_t              ctl_q,
   output logic [LANES-1:0]  lane_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= CTL_IDLE;
         lane_q <= '1;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         ctl_q  <= ctl_d;
         lane_q <= lane_d;
         addr_q <= addr_d;
         data_q <= data_d;
      end
   end

endmodule

// File: rtl/sram_wake_ctl.sv
module sram_wake_ctl #(
   parameter int WAKE_CYCLES = 3,
   localparam int CNT_W = $clog2(WAKE_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_q,
   output logic waking
);

   logic [CNT_W-1:0] cnt;

   // Reloaded while asleep, counts down once sleep is sampled low.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (sleep_q)
         cnt <= CNT_W'(WAKE_CYCLES);
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign waking = (cnt != '0);

   assert_wake_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_q) |-> waking);

   assert_wake_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(1) && !sleep_q) |=> !waking);

endmodule

// File: rtl/sram_access_dec.sv
module sram_access_dec
   import sram_ctl_pkg::*;
#(
   parameter int LANES = 4
) (
   input  ctl_t             ctl_q,
   input  logic [LANES-1:0] lane_q,
   input  logic             waking,
   input  logic             burst_q,
   output op_e              op,
   output logic [LANES-1:0] lane_we,
   output logic             burst_d,
   output logic             quiet
);

   logic wr_req;
   logic sel_all;
   logic p_start;

   always_comb begin
      wr_req  = !ctl_q.gwr_n || (!ctl_q.bwr_n && !(&lane_q));
      sel_all = !ctl_q.sel_a_n && ctl_q.sel_b && !ctl_q.sel_c_n;
      p_start = !ctl_q.pstb_n && !ctl_q.sel_a_n;
      quiet   = ctl_q.sleep || waking;
      op      = OP_NONE;
      burst_d = burst_q;
      if (quiet) begin
         burst_d = 1'b0;
      end else if (p_start) begin
         op      = OP_READ;
         burst_d = 1'b1;
      end else if (!ctl_q.cstb_n) begin
         burst_d = sel_all;
         if (sel_all)
            op = wr_req ? OP_WRITE : OP_READ;
      end else if (ctl_q.pstb_n && burst_q) begin
         op = wr_req ? OP_WRITE : OP_READ;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_mask
      assign lane_we[i] = (op == OP_WRITE) &&
                          (!ctl_q.gwr_n || (!ctl_q.bwr_n && !lane_q[i]));
   end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic [LANES-1:0]  lane_we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[i])
            mem[addr] <= wdata[i*LANE_W +: LANE_W];
      end

      assign rdata[i*LANE_W +: LANE_W] = mem[addr];
   end

endmodule

// File: rtl/sram_sync_core.sv
module sram_sync_core
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int LANES       = 4,
   parameter int LANE_W      = 8,
   parameter int WAKE_CYCLES = 3,
   localparam int DATA_W     = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_en,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              pstb_n,
   input  logic              cstb_n,
   input  logic              gwr_n,
   input  logic              bwr_n,
   input  logic [LANES-1:0]  lane_n,
   input  logic              oe_n,
   input  logic              sleep
);

   // Elaboration-time parameter checks.
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must lie in 1..12");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be positive");
   end
   if (WAKE_CYCLES < 1) begin : g_bad_wake
      $error("WAKE_CYCLES must be at least 1");
   end

   ctl_t              ctl_d, ctl_q;
   logic [LANES-1:0]  lane_q, lane_we;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q, rd_word, rd_word_q;
   logic              waking, quiet, burst_q, burst_d, rd_valid;
   op_e               op;

   assign ctl_d = '{sel_a_n: sel_a_n, sel_b: sel_b, sel_c_n: sel_c_n,
                    pstb_n: pstb_n, cstb_n: cstb_n, gwr_n: gwr_n,
                    bwr_n: bwr_n, sleep: sleep};

   sram_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
      .clk(clk), .rst_n(rst_n), .ctl_d(ctl_d), .lane_d(lane_n),
      .addr_d(addr), .data_d(dq_in), .ctl_q(ctl_q), .lane_q(lane_q),
      .addr_q(addr_q), .data_q(data_q));

   sram_wake_ctl #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
      .clk(clk), .rst_n(rst_n), .sleep_q(ctl_q.sleep), .waking(waking));

   sram_access_dec #(.LANES(LANES)) u_dec (
      .ctl_q(ctl_q), .lane_q(lane_q), .waking(waking), .burst_q(burst_q),
      .op(op), .lane_we(lane_we), .burst_d(burst_d), .quiet(quiet));

   sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk(clk), .lane_we(lane_we), .addr(addr_q), .wdata(data_q),
      .rdata(rd_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_q   <= 1'b0;
         rd_valid  <= 1'b0;
         rd_word_q <= '0;
      end else begin
         burst_q  <= burst_d;
         rd_valid <= (op == OP_READ);
         if (op == OP_READ)
            rd_word_q <= rd_word;
      end
   end

   assign dq_en  = rd_valid && !oe_n;
   assign dq_out = dq_en ? rd_word_q : '0;

   assert_pstart_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!quiet && !ctl_q.pstb_n && !ctl_q.sel_a_n) |-> (op == OP_READ && lane_we == '0));

   assert_global_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WRITE && !ctl_q.gwr_n) |-> (&lane_we));

   assert_lane_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WRITE && ctl_q.gwr_n) |-> (lane_we == ~lane_q));

   assert_desel_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q.cstb_n && (ctl_q.sel_a_n || !ctl_q.sel_b || ctl_q.sel_c_n) &&
       !(!ctl_q.pstb_n && !ctl_q.sel_a_n)) |=> !burst_q);

   assert_pstart_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q.pstb_n && ctl_q.sel_a_n && ctl_q.cstb_n) |-> (op == OP_NONE));

   assert_sleep_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |-> (lane_we == '0));

   assert_sleep_undriven_R10: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> !dq_en);

   assert_drive_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dq_en |-> $past(op == OP_READ));

endmodule

// File: tb/tb_sram_sync_core.sv
module tb_sram_sync_core;

   localparam int AW = 6;
   localparam int DW = 32;
   localparam int K_NONE = 0;
   localparam int K_P    = 1;
   localparam int K_C    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_en;
   logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
   logic          pstb_n = 1'b1, cstb_n = 1'b1;
   logic          gwr_n = 1'b1, bwr_n = 1'b1;
   logic [3:0]    lane_n = 4'hF;
   logic          oe_n = 1'b0, sleep = 1'b0;

   sram_sync_core #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_en(dq_en), .sel_a_n(sel_a_n), .sel_b(sel_b),
      .sel_c_n(sel_c_n), .pstb_n(pstb_n), .cstb_n(cstb_n), .gwr_n(gwr_n),
      .bwr_n(bwr_n), .lane_n(lane_n), .oe_n(oe_n), .sleep(sleep));

   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc++;

   typedef struct {
      int            due;
      bit            rd;
      logic [DW-1:0] data;
      string         req;
   } item_t;

   item_t         q[$];
   bit [DW-1:0]   model [64];
   int            checks = 0, fails = 0;
   bit            burst = 0;
   int            left = 0;
   bit            finished = 0;

   task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues the expected result.
   task automatic op(int kind, int a, logic [DW-1:0] d, bit gw, bit bw, logic [3:0] be, string req);
      bit quiet, wr, sel_all, rd, wop;
      rd = 0; wop = 0;
      pstb_n = (kind != K_P); cstb_n = (kind != K_C);
      addr = AW'(a); dq_in = d; gwr_n = gw; bwr_n = bw; lane_n = be;
      if (sleep) begin quiet = 1; left = 3; end
      else if (left > 0) begin quiet = 1; left--; end
      else quiet = 0;
      wr = !gw || (!bw && be != 4'hF);
      sel_all = !sel_a_n && sel_b && !sel_c_n;
      if (quiet) burst = 0;
      else if (kind == K_P && !sel_a_n) begin rd = 1; burst = 1; end
      else if (kind == K_C) begin
         burst = sel_all;
         if (sel_all) begin rd = !wr; wop = wr; end
      end else if (kind == K_NONE && burst) begin rd = !wr; wop = wr; end
      if (wop)
         for (int i = 0; i < 4; i++)
            if (!gw || (!bw && !be[i])) model[a][8*i +: 8] = d[8*i +: 8];
      q.push_back('{cyc + 2, rd, model[a], req});
      @(negedge clk);
   endtask

   // Monitor: compares the output against the queued expectation.
   initial begin
      forever begin
         @(posedge clk);
         #3;
         if (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            bit    exp_en;
            it = q.pop_front();
            exp_en = it.rd && !oe_n;
            check(dq_en == exp_en, it.req, "dq_en", DW'(dq_en), DW'(exp_en));
            if (exp_en) check(dq_out == it.data, it.req, "dq_out", dq_out, it.data);
            else        check(dq_out == '0, it.req, "dq_out idle", dq_out, '0);
         end
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(dq_en == 1'b0 && dq_out == '0, "R1", "reset output", dq_out, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 / R8: global write ignores bwr_n and lane_n, then read back.
      op(K_C, 5, 32'hDEADBEEF, 0, 1, 4'hF, "R3");
      op(K_C, 5, 32'h0, 1, 1, 4'hF, "R8");
      // R2: lane merges.
      op(K_C, 6, 32'h11223344, 0, 0, 4'h0, "R3");
      op(K_C, 6, 32'hAAAAAAAA, 1, 0, 4'b1110, "R2");
      op(K_C, 6, 32'hBBBBBBBB, 1, 0, 4'b0111, "R2");
      op(K_C, 6, 32'hCCCCCCCC, 1, 0, 4'b1001, "R2");
      op(K_C, 6, 32'h0, 1, 1, 4'hF, "R2");
      // R4: read decodes leave memory unchanged.
      op(K_C, 6, 32'h99999999, 1, 1, 4'h0, "R4");
      op(K_C, 6, 32'h99999999, 1, 0, 4'hF, "R4");
      // R5 / R11: processor start reads, continue cycle writes.
      op(K_C, 7, 32'h01020304, 0, 1, 4'hF, "R3");
      op(K_P, 7, 32'h55667788, 0, 0, 4'h0, "R5");
      op(K_NONE, 7, 32'h55667788, 0, 1, 4'hF, "R5");
      op(K_NONE, 7, 32'h0, 1, 1, 4'hF, "R5");
      op(K_NONE, 5, 32'h0, 1, 1, 4'hF, "R11");
      // R9: oe_n gates the output asynchronously.
      op(K_C, 5, 32'h0, 1, 1, 4'hF, "R9");
      oe_n = 1'b1;
      op(K_NONE, 6, 32'h0, 1, 1, 4'hF, "R9");
      oe_n = 1'b0;
      op(K_NONE, 6, 32'h0, 1, 1, 4'hF, "R9");
      // R6: each select mismatch blocks and ends the transfer.
      sel_b = 1'b0;
      op(K_C, 5, 32'h0, 1, 1, 4'hF, "R6");
      sel_b = 1'b1;
      op(K_NONE, 5, 32'h0BAD0BAD, 0, 1, 4'hF, "R6");
      sel_c_n = 1'b1;
      op(K_C, 5, 32'h0, 1, 1, 4'hF, "R6");
      sel_c_n = 1'b0; sel_a_n = 1'b1;
      op(K_C, 5, 32'h0, 1, 1, 4'hF, "R6");
      // R7: processor strobe without primary select.
      op(K_P, 5, 32'h0, 1, 1, 4'hF, "R7");
      op(K_NONE, 5, 32'h0BAD0BAD, 0, 1, 4'hF, "R7");
      sel_a_n = 1'b0;
      op(K_C, 5, 32'h0, 1, 1, 4'hF, "R6");
      // R10: sleep blocks, wake-up takes three edges, memory kept.
      op(K_C, 9, 32'hCAFEF00D, 0, 1, 4'hF, "R10");
      sleep = 1'b1;
      op(K_C, 9, 32'h12345678, 0, 1, 4'hF, "R10");
      op(K_C, 9, 32'h0, 1, 1, 4'hF, "R10");
      sleep = 1'b0;
      op(K_C, 9, 32'h0, 1, 1, 4'hF, "R10");
      op(K_C, 9, 32'h0, 1, 1, 4'hF, "R10");
      op(K_C, 9, 32'h0, 1, 1, 4'hF, "R10");
      op(K_C, 9, 32'h0, 1, 1, 4'hF, "R10");

      pstb_n = 1'b1; cstb_n = 1'b1;
      repeat (4) @(negedge clk);
      finished = 1;
      summary();
      $finish;
   end

endmodule